// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames as a byte stream and stores them in memory through a ring of descriptors. Each buffer holds 128 bytes. Each descriptor is two 32-bit words: an address word that points to a buffer, followed by a status word. When a frame starts, the block reads the address word of the current descriptor. If the buffer is free, it packs the incoming bytes into 32-bit words and writes them to that buffer. When the buffer fills or the frame ends, it writes the status word first and then hands the buffer to software by setting the ownership flag in the address word.

A frame longer than one buffer continues in the following descriptors. The descriptor that carries the wrap flag sends the walk back to the ring base, so a frame can run past the end of the ring and continue at its start. Software returns a buffer to the block by clearing its ownership flag. If the block needs a descriptor that software still holds, it discards the rest of the frame and signals an overrun. Lowering the enable input resets the walk to the ring base.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the block issues no memory request and holds `ovr_o` low, and the first frame uses the descriptor at `ring_base_i`.
- R2: At the start of a frame the block reads the address word of the current descriptor at `ring_base_i + 8*i`. It forms the buffer pointer from that word with bits 1:0 cleared.
- R3: Frame byte k of a buffer is stored at byte offset k of that buffer, little-endian within 32-bit words. A partial last word has its unused bytes set to zero. While a descriptor access or a data write is under way, `rx_ready_o` is low.
- R4: Each buffer takes at most 128 bytes. A longer frame continues in the buffer of the next descriptor.
- R5: Status word layout: bit 14 is set only on the first buffer of a frame, and bit 15 only on the last. Bits 11:0 hold the total frame length on the last buffer and are 0 on the other buffers. All other bits are 0, except as R6 states.
- R6: Bit 31 of the last buffer's status word is set only when the frame has at least 6 bytes and its first 6 bytes are all 0xFF.
- R7: After filling a buffer, the block writes the status word at descriptor+4. In the next cycle it rewrites the address word with bit 0 (ownership) set and bits 31:1 unchanged.
- R8: After using a descriptor whose address word has bit 1 (wrap) set, the next descriptor is the one at `ring_base_i`. A frame may continue across this wrap.
- R9: If the fetched address word already has bit 0 set, `ovr_o` pulses for one cycle. The rest of the frame is consumed with no memory write, and the descriptor pointer does not advance. Buffers already filled for that frame remain handed over.
- R10: While `en_i` is low, bytes are accepted and discarded and no memory request is made. The next frame after re-enabling uses the descriptor at `ring_base_i`.
- R11: While idle, a byte without the start marker is accepted and discarded with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Receive enable; low resets the walk to the ring base |
| ring_base_i | input | 32 | Byte address of descriptor 0 |
| rx_valid_i | input | 1 | Byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_ready_o | output | 1 | Byte accepted when high together with rx_valid_i |
| mem_req_o | output | 1 | Memory access this cycle (always granted) |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| ovr_o | output | 1 | One-cycle pulse when a needed descriptor is still owned by software |

## Verification
The hardest case to reach is an overrun in the middle of a frame. It needs one buffer already filled and handed over, and the next descriptor still owned by software. The bench prepares this by returning every descriptor except the one after the current pointer. It then sends a 200-byte frame. The check confirms that the first buffer carries only the start flag, that exactly one overrun pulse occurs, and that the next frame lands in the descriptor that was held. Frame lengths are swept across the word and buffer boundaries (1 to 8, 127 to 129, 256, and lengths that span three buffers). This sweep drives the ring through its wrap point several times.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int OWN_B  = 0;
  localparam int WRAP_B = 1;
  localparam int SOF_B  = 14;
  localparam int EOF_B  = 15;
  localparam int BC_B   = 31;
  localparam int LEN_W  = 12;
  localparam int BC_HDR = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_DATA, S_WRD, S_WST, S_WOWN, S_DROP
  } st_t;
endpackage

// File: rtl/rxr_desc_ptr.sv
module rxr_desc_ptr #(
  parameter int OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             home_i,
  input  logic             step_i,
  input  logic             wrap_i,
  output logic [OFF_W-1:0] off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_o <= '0;
    else if (home_i) off_o <= '0;
    else if (step_i) off_o <= wrap_i ? '0 : off_o + OFF_W'(8);
  end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int BUF_BYTES = 128,
  localparam int CNT_W  = $clog2(BUF_BYTES) + 1,
  localparam int WIDX_W = $clog2(BUF_BYTES / 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  input  logic              flush_i,
  output logic [31:0]       word_o,
  output logic [1:0]        lane_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WIDX_W-1:0] widx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      lane_o <= '0;
      cnt_o  <= '0;
      widx_o <= '0;
    end else if (clr_i) begin
      word_o <= '0;
      lane_o <= '0;
      cnt_o  <= '0;
      widx_o <= '0;
    end else if (push_i) begin
      word_o[8*lane_o +: 8] <= byte_i;
      lane_o <= lane_o + 2'd1;
      cnt_o  <= cnt_o + CNT_W'(1);
    end else if (flush_i) begin
      word_o <= '0;
      widx_o <= widx_o + WIDX_W'(1);
    end
  end
endmodule

// File: rtl/rxr_bcast.sv
module rxr_bcast
  import rxr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  logic [7:0] byte_i,
  output logic       bc_o
);
  logic [2:0] seen_q;
  logic       all_ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= '0;
      all_ff_q <= 1'b1;
    end else if (clr_i) begin
      seen_q   <= '0;
      all_ff_q <= 1'b1;
    end else if (push_i && seen_q < 3'(BC_HDR)) begin
      seen_q   <= seen_q + 3'd1;
      all_ff_q <= all_ff_q && (byte_i == 8'hFF);
    end
  end

  assign bc_o = all_ff_q && (seen_q == 3'(BC_HDR));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int OFF_W     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [31:0] ring_base_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  output logic        rx_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  output logic        ovr_o
);
  localparam int CNT_W  = $clog2(BUF_BYTES) + 1;
  localparam int WIDX_W = $clog2(BUF_BYTES / 4);

  st_t               st, st_n;
  logic [31:0]       buf_base;
  logic              wrap_q, sof_q, eof_q;
  logic [LEN_W-1:0]  flen;
  logic [OFF_W-1:0]  off;
  logic [31:0]       word, desc_addr, stat_word;
  logic [1:0]        lane;
  logic [CNT_W-1:0]  cnt;
  logic [WIDX_W-1:0] widx;
  logic              bc, acc, push, frame_start, owned;

  assign desc_addr   = ring_base_i + 32'(off);
  assign acc         = rx_valid_i && rx_ready_o;
  assign push        = en_i && acc && (st == S_DATA);
  assign frame_start = en_i && (st == S_IDLE) && rx_valid_i && rx_sof_i;
  assign owned       = mem_rdata_i[OWN_B];
  assign ovr_o       = en_i && (st == S_CHK) && owned;

  rxr_desc_ptr #(.OFF_W(OFF_W)) u_ptr (
    .clk_i, .rst_ni,
    .home_i (!en_i),
    .step_i (en_i && st == S_WOWN),
    .wrap_i (wrap_q),
    .off_o  (off)
  );

  rxr_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk_i, .rst_ni,
    .clr_i   (st == S_CHK),
    .push_i  (push),
    .byte_i  (rx_data_i),
    .flush_i (en_i && st == S_WRD),
    .word_o  (word),
    .lane_o  (lane),
    .cnt_o   (cnt),
    .widx_o  (widx)
  );

  rxr_bcast u_bc (
    .clk_i, .rst_ni,
    .clr_i  (frame_start),
    .push_i (push),
    .byte_i (rx_data_i),
    .bc_o   (bc)
  );

  always_comb begin
    stat_word        = '0;
    stat_word[SOF_B] = sof_q;
    if (eof_q) begin
      stat_word[EOF_B]       = 1'b1;
      stat_word[BC_B]        = bc;
      stat_word[LEN_W-1:0]   = flen;
    end
  end

  always_comb begin
    if (!en_i) rx_ready_o = 1'b1;
    else begin
      case (st)
        S_IDLE:         rx_ready_o = !(rx_valid_i && rx_sof_i);
        S_DATA, S_DROP: rx_ready_o = 1'b1;
        default:        rx_ready_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_wdata_o = '0;
    case (st)
      S_RD:  mem_req_o = en_i;
      S_WRD: begin
        mem_req_o   = en_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_base + 32'({widx, 2'b00});
        mem_wdata_o = word;
      end
      S_WST: begin
        mem_req_o   = en_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + 32'd4;
        mem_wdata_o = stat_word;
      end
      S_WOWN: begin
        mem_req_o   = en_i;
        mem_we_o    = 1'b1;
        mem_wdata_o = {buf_base[31:2], wrap_q, 1'b1};
      end
      default: ;
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (rx_valid_i && rx_sof_i) st_n = S_RD;
      S_RD:   st_n = S_CHK;
      S_CHK:  st_n = owned ? S_DROP : S_DATA;
      S_DATA: if (push && (lane == 2'd3 || rx_eof_i)) st_n = S_WRD;
      S_WRD:  st_n = (eof_q || cnt == CNT_W'(BUF_BYTES)) ? S_WST : S_DATA;
      S_WST:  st_n = S_WOWN;
      S_WOWN: st_n = eof_q ? S_IDLE : S_RD;
      S_DROP: if (acc && rx_eof_i) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (!en_i) st_n = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_IDLE;
      buf_base <= '0;
      wrap_q   <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      flen     <= '0;
    end else begin
      st <= st_n;
      if (frame_start) begin
        sof_q <= 1'b1;
        eof_q <= 1'b0;
        flen  <= '0;
      end
      if (push) begin
        flen <= flen + LEN_W'(1);
        if (rx_eof_i) eof_q <= 1'b1;
      end
      if (en_i && st == S_CHK && !owned) begin
        buf_base <= {mem_rdata_i[31:2], 2'b00};
        wrap_q   <= mem_rdata_i[WRAP_B];
      end
      if (en_i && st == S_WOWN) sof_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 128
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input st_t         st,
  input logic        rx_ready_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic [31:0] buf_base,
  input logic        ovr_o
);
  p_ovr_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> !ovr_o && !mem_req_o);

  p_disable_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st == S_IDLE);

  p_stat_before_own_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st == S_WOWN) |-> $past(st) == S_WST && $past(mem_addr_o) == mem_addr_o + 32'd4);

  p_own_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st == S_WOWN) |-> mem_req_o && mem_we_o && mem_wdata_o[OWN_B]);

  p_data_in_buf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && st == S_WRD) |-> (mem_addr_o - buf_base) < 32'(BUF_BYTES));

  p_busy_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st inside {S_RD, S_CHK, S_WRD, S_WST, S_WOWN}) |-> !rx_ready_o);
endmodule

bind rx_ring_writer rxr_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .st          (st),
  .rx_ready_o  (rx_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .buf_base    (buf_base),
  .ovr_o       (ovr_o)
);

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  localparam int NDESC = 4;
  localparam int BUFA  = 32'h400;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] ring_base_i = 32'h0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = 8'h0;
  logic        rx_sof_i = 1'b0;
  logic        rx_eof_i = 1'b0;
  logic        rx_ready_o, mem_req_o, mem_we_o, ovr_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;

  logic [31:0] mem [0:1023];
  int nchk = 0, nfail = 0, nwr = 0, nreq = 0, novr = 0, ptr = 0;
  logic        prev_we = 1'b0;
  logic [31:0] prev_addr = '0;

  always #4 clk_i = ~clk_i;

  rx_ring_writer uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      nreq++;
      if (mem_we_o) begin
        mem[mem_addr_o[11:2]] <= mem_wdata_o;
        nwr++;
        // R7: an ownership write to an address word follows the status write
        if (mem_addr_o < 32'(8 * NDESC) && !mem_addr_o[2] && mem_wdata_o[0])
          chk(prev_we && prev_addr == mem_addr_o + 32'd4, "R7 status-before-own",
              prev_addr, mem_addr_o + 32'd4);
      end else mem_rdata_i <= mem[mem_addr_o[11:2]];
    end
    prev_we   <= mem_req_o && mem_we_o;
    prev_addr <= mem_addr_o;
    if (ovr_o) novr++;
  end

  function automatic logic [7:0] pat(int len, int j, int nff);
    if (j < nff) return 8'hFF;
    return 8'(j * 7 + len * 3 + 1);
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    bit r;
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = d; rx_sof_i = s; rx_eof_i = e;
    do begin
      #3 r = rx_ready_o;
      @(posedge clk_i);
    end while (!r);
  endtask

  task automatic send_frame(input int len, input int nff);
    for (int j = 0; j < len; j++) send_byte(pat(len, j, nff), j == 0, j == len - 1);
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic release_all();
    @(negedge clk_i);
    for (int i = 0; i < NDESC; i++) mem[2 * i][0] = 1'b0;
  endtask

  function automatic logic [31:0] addr_word(int d);
    return 32'(BUFA + 128 * d) | ((d == NDESC - 1) ? 32'h2 : 32'h0);
  endfunction

  task automatic check_frame(input int start, input int len, input int nff);
    int nbuf, d, n;
    logic [31:0] es, ew;
    bit bc;
    nbuf = (len + 127) / 128;
    bc = (nff >= 6) && (len >= 6);
    for (int k = 0; k < nbuf; k++) begin
      d = (start + k) % NDESC;
      n = (len - 128 * k > 128) ? 128 : len - 128 * k;
      es = 0;
      if (k == 0) es[14] = 1'b1;
      if (k == nbuf - 1) begin
        es[15] = 1'b1; es[31] = bc; es[11:0] = 12'(len);
      end
      chk(mem[2 * d + 1] == es, "R5/R6 status word", mem[2 * d + 1], es);
      chk(mem[2 * d] == (addr_word(d) | 32'h1), "R7/R8 ownership", mem[2 * d], addr_word(d) | 32'h1);
      for (int w = 0; w < (n + 3) / 4; w++) begin
        ew = 0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < n) ew[8 * b +: 8] = pat(len, 128 * k + 4 * w + b, nff);
        chk(mem[(BUFA + 128 * d) / 4 + w] == ew, "R3/R4 buffer data", mem[(BUFA + 128 * d) / 4 + w], ew);
      end
    end
    ptr = (start + nbuf) % NDESC;
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int lens [15] = '{1, 2, 3, 4, 5, 6, 7, 8, 127, 128, 129, 200, 256, 300, 383};
    int w0, o0, r0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < NDESC; i++) mem[2 * i] = addr_word(i);
    repeat (4) @(negedge clk_i);
    chk(mem_req_o == 1'b0, "R1 no request in reset", 32'(mem_req_o), 0);
    chk(ovr_o == 1'b0, "R1 ovr low in reset", 32'(ovr_o), 0);
    rst_ni = 1'b1; en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(nreq == 0, "R1 idle after reset", 32'(nreq), 0);

    // R11: stray byte without start marker
    r0 = nreq;
    send_byte(8'h55, 1'b0, 1'b0);
    @(negedge clk_i); rx_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(nreq == r0, "R11 stray byte ignored", 32'(nreq), 32'(r0));

    // R2..R8: length sweep, broadcast header varied, ring wraps repeatedly
    foreach (lens[i]) begin
      release_all();
      send_frame(lens[i], (i % 3 == 0) ? 6 : (i % 3 == 1) ? 5 : 0);
      check_frame(ptr, lens[i], (i % 3 == 0) ? 6 : (i % 3 == 1) ? 5 : 0);
    end
    release_all();
    send_frame(10, 10);
    check_frame(ptr, 10, 10);

    // R9: descriptor still owned at frame start
    release_all();
    mem[2 * ptr][0] = 1'b1;
    w0 = nwr; o0 = novr;
    send_frame(20, 0);
    chk(novr == o0 + 1, "R9 one overrun pulse", 32'(novr - o0), 1);
    chk(nwr == w0, "R9 dropped frame writes nothing", 32'(nwr - w0), 0);
    release_all();
    send_frame(10, 0);
    check_frame(ptr, 10, 0);

    // R9: overrun in mid-frame
    release_all();
    mem[2 * ((ptr + 1) % NDESC)][0] = 1'b1;
    o0 = novr;
    send_frame(200, 0);
    chk(novr == o0 + 1, "R9 mid-frame overrun pulse", 32'(novr - o0), 1);
    chk(mem[2 * ptr + 1] == 32'h4000, "R9 first buffer start only", mem[2 * ptr + 1], 32'h4000);
    chk(mem[2 * ptr] == (addr_word(ptr) | 1), "R9 first buffer handed over", mem[2 * ptr], addr_word(ptr) | 1);
    ptr = (ptr + 1) % NDESC;
    release_all();
    send_frame(9, 0);
    check_frame(ptr, 9, 0);

    // R10: disable returns to ring base
    if (ptr == 0) begin
      release_all(); send_frame(3, 0); check_frame(ptr, 3, 0);
    end
    @(negedge clk_i); en_i = 1'b0;
    r0 = nreq;
    send_frame(5, 0);
    chk(nreq == r0, "R10 no request while disabled", 32'(nreq - r0), 0);
    @(negedge clk_i); en_i = 1'b1;
    release_all();
    send_frame(12, 0);
    check_frame(0, 12, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule